// File: doc/BRIEF.md
# Restricted RISC-V Instruction Legality Screen

This block inspects a code array one halfword parcel at a time and decides, for every instruction it assembles, whether that instruction belongs to a restricted 64-bit embedded RISC-V profile. The profile keeps the 16-register base, compressed forms, multiply/divide and the common bit-manipulation and conditional-zero groups. It also admits five host and control operations in the custom-0 slot. It rejects all indirect jumps, PC-relative upper immediates, system, CSR, atomic, floating-point and vector encodings, the custom-1 slot, and any use of registers x3, x4 or x16 to x31.

The loader feeds parcels in stream order, each with its byte offset and a valid strobe. Idle cycles may occur at any point, including between the two halves of a 32-bit instruction. For every instruction the block emits one result pulse that carries a legal flag and the instruction's starting offset. A sticky reject flag records the offset of the first illegal instruction in the stream. Only reset clears it.

Top module: `rv_legality_screen`

## Requirements
- R1: A parcel whose bits [1:0] are not 11 is a complete 16-bit instruction. A parcel with bits [1:0] = 11 is the lower half of a 32-bit instruction, and the next valid parcel supplies bits [31:16]. The reported offset is always that of the instruction's first parcel.
- R2: Each instruction produces exactly one result pulse, on the clock edge that samples its completing parcel. The lower half of a 32-bit instruction produces none.
- R3: The following 32-bit major opcodes are illegal: 0010111 (upper immediate plus PC), 1100111 (register-indirect jump), 1110011 (environment call, breakpoint, CSR and privileged operations), 0101111 (atomics) and 0101011 (custom-1).
- R4: Floating-point and vector encodings are illegal. This covers the 32-bit opcodes 0000111, 0100111, 1000011, 1000111, 1001011, 1001111, 1010011 and 1010111, and the compressed double-precision load/store forms (quadrants 00 and 10, funct3 001 and 101).
- R5: A register field that the format actually uses is illegal if it names x3, x4 or any of x16 to x31. Immediate fields and fields the format does not use are never screened.
- R6: Custom-0 (0001011) with funct3 000 to 100 is legal, and funct3 101 to 111 is illegal. Funct3 011 (table branch) also requires rd = 0 and has its rs1 field screened. The other custom-0 forms have no screened register fields.
- R7: Opcode 0001111 is legal with funct3 000 (memory fence) or 001 (instruction fence) and illegal with any other funct3.
- R8: Compressed quadrant 10 with funct3 100 and rs2 field [6:2] = 0 is illegal, whatever rs1 holds. This covers every register-jump, register-jump-and-link and breakpoint form, including 0x8082. With rs2 nonzero the register move and add forms are legal.
- R9: The following reserved compressed forms are illegal: the stack-pointer add-immediate with a zero immediate (including halfword 0x0000), quadrant 00 funct3 100, the stack-relative loads (quadrant 10, funct3 010 and 011) with rd = 0, the 32-bit add-immediate (quadrant 01, funct3 001) with rd = 0, quadrant 01 funct3 011 with a zero immediate, and quadrant 01 funct3 100 with [12:10] = 111 and bit 6 set.
- R10: In register-register opcode 0110011, funct7 must be one of 0x00, 0x20, 0x01, 0x10, 0x24, 0x14, 0x34, 0x30, 0x05 or 0x07. In opcode 0111011 it must be one of 0x00, 0x20, 0x01, 0x10, 0x04 or 0x30.
- R11: The following sub-encodings are illegal: branch (1100011) funct3 010 and 011, load (0000011) funct3 111, store (0100011) funct3 100 to 111, 0011011 with any funct3 other than 000, 001 and 101, and 0111011 funct3 011. Any major opcode not named in R3 to R11 (0110111, 1101111, 0010011, 0110011 and the listed groups) is illegal.
- R12: The reject flag rises with the first illegal result and holds that instruction's offset. Later illegal instructions change neither the flag nor the offset until reset.
- R13: After reset, no result is pending, no half-instruction is held, and the reject flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Parcel strobe |
| in_parcel | input | 16 | Instruction halfword |
| in_off | input | OFF_W | Byte offset of the parcel |
| res_valid | output | 1 | One-cycle result pulse per instruction |
| res_legal | output | 1 | Instruction is legal |
| res_off | output | OFF_W | Offset of the instruction's first parcel |
| rej_flag | output | 1 | Sticky: an illegal instruction was seen |
| rej_off | output | OFF_W | Offset of the first illegal instruction |

## Verification
A 16-bit instruction's result is due on the first rising edge after its parcel is presented. A 32-bit instruction's result is due on the edge that samples its upper half, so its lower half and any idle cycles in between produce no pulse. The reject flag and offset are updated on that same edge. The driver queues the expected legality and offset at the moment it presents a completing parcel, and the monitor compares at the next falling edge whenever a pulse is present, flagging any pulse that arrives with nothing queued. The reject state is read two idle cycles after a stream ends, once every result has left the block.

// File: rtl/rvls_pkg.sv
package rvls_pkg;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OPIMMW = 7'b0011011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPW    = 7'b0111011;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_CUST0  = 7'b0001011;

  localparam int unsigned REG_W = 5;

  // Register is outside the usable set: x3, x4 or beyond the 16-entry file.
  function automatic logic reg_bad(input logic [REG_W-1:0] r);
    return r[4] || (r == 5'd3) || (r == 5'd4);
  endfunction

  function automatic logic op_f7_ok(input logic [6:0] f7);
    case (f7)
      7'h00, 7'h20, 7'h01, 7'h10, 7'h24,
      7'h14, 7'h34, 7'h30, 7'h05, 7'h07: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  function automatic logic opw_f7_ok(input logic [6:0] f7);
    case (f7)
      7'h00, 7'h20, 7'h01, 7'h10, 7'h04, 7'h30: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rvls_join.sv
module rvls_join #(
  parameter int unsigned OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [15:0]      in_parcel,
  input  logic [OFF_W-1:0] in_off,
  output logic             emit_valid,
  output logic             emit_wide,
  output logic [31:0]      emit_insn,
  output logic [OFF_W-1:0] emit_off
);

  logic             pend_q, pend_d;
  logic [15:0]      lo_q, lo_d;
  logic [OFF_W-1:0] lo_off_q, lo_off_d;
  logic             starts_wide;

  assign starts_wide = (in_parcel[1:0] == 2'b11);

  always_comb begin
    emit_valid = in_valid && (pend_q || !starts_wide);
    emit_wide  = pend_q;
    emit_insn  = pend_q ? {in_parcel, lo_q} : {16'h0000, in_parcel};
    emit_off   = pend_q ? lo_off_q : in_off;

    pend_d   = pend_q;
    lo_d     = lo_q;
    lo_off_d = lo_off_q;
    if (in_valid) begin
      if (pend_q) begin
        pend_d = 1'b0;
      end else if (starts_wide) begin
        pend_d   = 1'b1;
        lo_d     = in_parcel;
        lo_off_d = in_off;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      lo_q     <= '0;
      lo_off_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (in_valid && !pend_q && starts_wide) begin
        lo_q     <= lo_d;
        lo_off_q <= lo_off_d;
      end
    end
  end

endmodule

// File: rtl/rvls_chk16.sv
module rvls_chk16
  import rvls_pkg::*;
(
  input  logic [15:0] half,
  output logic        legal
);

  logic [1:0] quad;
  logic [2:0] f3;
  logic [4:0] rd, rs2;
  logic       ok, use_rd, use_rs2;

  always_comb begin
    quad    = half[1:0];
    f3      = half[15:13];
    rd      = half[11:7];
    rs2     = half[6:2];
    ok      = 1'b0;
    use_rd  = 1'b0;
    use_rs2 = 1'b0;
    case (quad)
      2'b00: begin
        case (f3)
          3'b000:                    ok = (half[12:5] != 8'h00);
          3'b010, 3'b011,
          3'b110, 3'b111:            ok = 1'b1;
          default:                   ok = 1'b0;
        endcase
      end
      2'b01: begin
        case (f3)
          3'b000, 3'b010: begin ok = 1'b1;           use_rd = 1'b1; end
          3'b001:         begin ok = (rd != 5'd0);   use_rd = 1'b1; end
          3'b011: begin
            ok     = ({half[12], half[6:2]} != 6'd0);
            use_rd = 1'b1;
          end
          3'b100:  ok = !((half[12:10] == 3'b111) && half[6]);
          default: ok = 1'b1;
        endcase
      end
      2'b10: begin
        case (f3)
          3'b000:         begin ok = 1'b1;         use_rd = 1'b1; end
          3'b010, 3'b011: begin ok = (rd != 5'd0); use_rd = 1'b1; end
          3'b100: begin
            ok      = (rs2 != 5'd0);
            use_rd  = 1'b1;
            use_rs2 = 1'b1;
          end
          3'b110, 3'b111: begin ok = 1'b1; use_rs2 = 1'b1; end
          default:        ok = 1'b0;
        endcase
      end
      default: ok = 1'b0;
    endcase
    legal = ok && !(use_rd && reg_bad(rd)) && !(use_rs2 && reg_bad(rs2));
  end

endmodule

// File: rtl/rvls_chk32.sv
module rvls_chk32
  import rvls_pkg::*;
(
  input  logic [31:0] word,
  output logic        legal
);

  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [4:0] rd, rs1, rs2;
  logic       ok, use_rd, use_rs1, use_rs2;

  always_comb begin
    opc     = word[6:0];
    rd      = word[11:7];
    f3      = word[14:12];
    rs1     = word[19:15];
    rs2     = word[24:20];
    f7      = word[31:25];
    ok      = 1'b0;
    use_rd  = 1'b0;
    use_rs1 = 1'b0;
    use_rs2 = 1'b0;
    case (opc)
      OPC_LUI, OPC_JAL: begin ok = 1'b1; use_rd = 1'b1; end
      OPC_BRANCH: begin
        ok = (f3 != 3'b010) && (f3 != 3'b011);
        use_rs1 = 1'b1; use_rs2 = 1'b1;
      end
      OPC_LOAD: begin
        ok = (f3 != 3'b111);
        use_rd = 1'b1; use_rs1 = 1'b1;
      end
      OPC_STORE: begin
        ok = !f3[2];
        use_rs1 = 1'b1; use_rs2 = 1'b1;
      end
      OPC_OPIMM: begin ok = 1'b1; use_rd = 1'b1; use_rs1 = 1'b1; end
      OPC_OPIMMW: begin
        ok = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b101);
        use_rd = 1'b1; use_rs1 = 1'b1;
      end
      OPC_OP: begin
        ok = op_f7_ok(f7);
        use_rd = 1'b1; use_rs1 = 1'b1; use_rs2 = 1'b1;
      end
      OPC_OPW: begin
        ok = (f3 != 3'b011) && opw_f7_ok(f7);
        use_rd = 1'b1; use_rs1 = 1'b1; use_rs2 = 1'b1;
      end
      OPC_FENCE: ok = (f3 == 3'b000) || (f3 == 3'b001);
      OPC_CUST0: begin
        ok      = (f3 <= 3'b100) && !((f3 == 3'b011) && (rd != 5'd0));
        use_rs1 = (f3 == 3'b011);
      end
      default: ok = 1'b0;
    endcase
    legal = ok && !(use_rd && reg_bad(rd)) && !(use_rs1 && reg_bad(rs1))
               && !(use_rs2 && reg_bad(rs2));
  end

endmodule

// File: rtl/rv_legality_screen.sv
module rv_legality_screen #(
  parameter int unsigned OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [15:0]      in_parcel,
  input  logic [OFF_W-1:0] in_off,
  output logic             res_valid,
  output logic             res_legal,
  output logic [OFF_W-1:0] res_off,
  output logic             rej_flag,
  output logic [OFF_W-1:0] rej_off
);

  logic             emit_valid, emit_wide;
  logic [31:0]      emit_insn;
  logic [OFF_W-1:0] emit_off;
  logic             ok16, ok32, legal_now;

  logic             res_valid_q, res_valid_d;
  logic             res_legal_q, res_legal_d;
  logic [OFF_W-1:0] res_off_q, res_off_d;
  logic             rej_q, rej_d;
  logic [OFF_W-1:0] rej_off_q, rej_off_d;
  logic             res_en, rej_en;

  rvls_join #(.OFF_W(OFF_W)) u_join (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_parcel  (in_parcel),
    .in_off     (in_off),
    .emit_valid (emit_valid),
    .emit_wide  (emit_wide),
    .emit_insn  (emit_insn),
    .emit_off   (emit_off)
  );

  rvls_chk16 u_chk16 (
    .half  (emit_insn[15:0]),
    .legal (ok16)
  );

  rvls_chk32 u_chk32 (
    .word  (emit_insn),
    .legal (ok32)
  );

  always_comb begin
    legal_now   = emit_wide ? ok32 : ok16;
    res_en      = emit_valid;
    res_valid_d = emit_valid;
    res_legal_d = legal_now;
    res_off_d   = emit_off;
    rej_en      = emit_valid && !legal_now && !rej_q;
    rej_d       = 1'b1;
    rej_off_d   = emit_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_legal_q <= 1'b0;
      res_off_q   <= '0;
      rej_q       <= 1'b0;
      rej_off_q   <= '0;
    end else begin
      res_valid_q <= res_valid_d;
      if (res_en) begin
        res_legal_q <= res_legal_d;
        res_off_q   <= res_off_d;
      end
      if (rej_en) begin
        rej_q     <= rej_d;
        rej_off_q <= rej_off_d;
      end
    end
  end

  assign res_valid = res_valid_q;
  assign res_legal = res_legal_q;
  assign res_off   = res_off_q;
  assign rej_flag  = rej_q;
  assign rej_off   = rej_off_q;

endmodule

// File: rtl/rvls_sva.sv
module rvls_sva #(
  parameter int unsigned OFF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             res_valid,
  input logic             res_legal,
  input logic             rej_flag,
  input logic [OFF_W-1:0] rej_off
);

  // R12
  reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_flag |=> rej_flag && $stable(rej_off));

  // R12
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rej_flag) |-> res_valid && !res_legal);

  // R12
  illegal_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_legal) |-> rej_flag);

  // R2
  result_needs_parcel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(in_valid));

endmodule

bind rv_legality_screen rvls_sva #(.OFF_W(OFF_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .res_valid (res_valid),
  .res_legal (res_legal),
  .rej_flag  (rej_flag),
  .rej_off   (rej_off)
);

// File: tb/tb_rv_legality_screen.sv
`timescale 1ns/1ps
module tb_rv_legality_screen;

  localparam int unsigned OFF_W = 32;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [15:0]      in_parcel;
  logic [OFF_W-1:0] in_off;
  logic             res_valid, res_legal, rej_flag;
  logic [OFF_W-1:0] res_off, rej_off;

  rv_legality_screen #(.OFF_W(OFF_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_parcel (in_parcel),
    .in_off    (in_off),
    .res_valid (res_valid),
    .res_legal (res_legal),
    .res_off   (res_off),
    .rej_flag  (rej_flag),
    .rej_off   (rej_off)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];
  logic [OFF_W-1:0] cur_off;
  logic             seen_bad;
  logic [OFF_W-1:0] first_bad;
  bit               done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [15:0] p);
    @(negedge clk);
    in_valid  = 1'b1;
    in_parcel = p;
    in_off    = cur_off;
    cur_off   = cur_off + 2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic expect_item(input logic [OFF_W-1:0] off, input bit legal,
                             input string tag);
    exp_q.push_back({legal, off});
    tag_q.push_back(tag);
    if (!legal && !seen_bad) begin
      seen_bad  = 1'b1;
      first_bad = off;
    end
  endtask

  task automatic send16(input logic [15:0] h, input bit legal, input string tag);
    logic [OFF_W-1:0] o;
    o = cur_off;
    drive(h);
    expect_item(o, legal, tag);
  endtask

  task automatic send32(input logic [31:0] w, input bit legal, input string tag,
                        input int gap);
    logic [OFF_W-1:0] o;
    o = cur_off;
    drive(w[15:0]);
    if (gap > 0) idle(gap);
    drive(w[31:16]);
    expect_item(o, legal, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    cur_off  = '0;
    seen_bad = 1'b0;
    first_bad = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: compare each result pulse against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result pulse", {32'd0, res_off}, 64'd0);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(res_legal == e[32], t, {63'd0, res_legal}, {63'd0, e[32]});
          check(res_off == e[31:0], {t, " R1 offset"}, {32'd0, res_off}, {32'd0, e[31:0]});
        end
      end
    end
  end

  // watchdog
  initial begin
    for (int i = 0; i < 50000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_parcel = '0; in_off = '0;
    cur_off = '0; seen_bad = 1'b0; first_bad = '0;
    do_reset();
    @(negedge clk);
    // R13 reset state
    check(!res_valid, "R13 res_valid after reset", {63'd0, res_valid}, 64'd0);
    check(!rej_flag, "R13 rej_flag after reset", {63'd0, rej_flag}, 64'd0);

    // legal prefix, mixed widths
    send32(32'h00510093, 1'b1, "R1 addi x1,x2,5", 0);
    send16(16'h4285,     1'b1, "R1 c.li x5,1");
    send32(32'h00300293, 1'b1, "R5 imm equal 3 not screened", 2);
    send16(16'h0001,     1'b1, "R1 c.nop");
    send32(32'h0FF0000F, 1'b1, "R7 fence", 0);
    send32(32'h0000100F, 1'b1, "R7 fence.i", 0);
    send32(32'h0000000B, 1'b1, "R6 custom0 f3=000", 0);
    send32(32'h0000400B, 1'b1, "R6 custom0 f3=100", 0);
    send32(32'h0050B00B, 1'b1, "R6 table branch rd=0", 0);
    send32(32'h0000218B, 1'b1, "R6 custom0 f3=010 rd bits 3 unscreened", 0);
    send16(16'h808A,     1'b1, "R8 c.mv x1,x2");
    send16(16'h9426,     1'b1, "R8 c.add x8,x9");
    send32(32'h025100B3, 1'b1, "R10 mul funct7 01", 0);
    send32(32'h123452B7, 1'b1, "R11 lui", 0);
    send32(32'h0000006F, 1'b1, "R11 jal x0", 0);
    send32(32'h00208063, 1'b1, "R11 beq", 1);
    send32(32'h00113023, 1'b1, "R11 sd", 0);
    send16(16'h4082,     1'b1, "R9 c.lwsp x1 legal");
    send16(16'h9C01,     1'b1, "R9 c.subw legal");
    send16(16'hA001,     1'b1, "R1 c.j");
    idle(2);
    // R12 no reject while only legal instructions seen
    check(!rej_flag, "R12 no reject on legal stream", {63'd0, rej_flag}, 64'd0);

    // illegal mix
    send32(32'h00000097, 1'b0, "R3 auipc", 0);
    send32(32'h00008067, 1'b0, "R3 jalr", 0);
    send32(32'h00000073, 1'b0, "R3 ecall", 0);
    send32(32'h300110F3, 1'b0, "R3 csrrw", 0);
    send32(32'h30200073, 1'b0, "R3 mret", 0);
    send32(32'h0022A0AF, 1'b0, "R3 amo", 0);
    send32(32'h0000002B, 1'b0, "R3 custom1", 0);
    send32(32'h00012087, 1'b0, "R4 float load", 0);
    send16(16'h2000,     1'b0, "R4 c.fld");
    send32(32'h00100193, 1'b0, "R5 rd x3", 0);
    send32(32'h002200B3, 1'b0, "R5 rs1 x4", 0);
    send32(32'h00108833, 1'b0, "R5 rd x16", 0);
    send16(16'h4185,     1'b0, "R5 c.li x3");
    send16(16'h8092,     1'b0, "R5 c.mv rs2 x4");
    send32(32'h0050B08B, 1'b0, "R6 table branch rd!=0", 0);
    send32(32'h0051B00B, 1'b0, "R6 table branch rs1 x3", 0);
    send32(32'h0000500B, 1'b0, "R6 custom0 f3=101", 0);
    send32(32'h0000200F, 1'b0, "R7 fence f3=010", 0);
    send16(16'h8082,     1'b0, "R8 c.jr ra");
    send16(16'h9082,     1'b0, "R8 c.jalr");
    send16(16'h9002,     1'b0, "R8 c.ebreak");
    send16(16'h0000,     1'b0, "R9 zero halfword");
    send16(16'h4002,     1'b0, "R9 c.lwsp rd=0");
    send16(16'h9C41,     1'b0, "R9 reserved alu group");
    send32(32'hFE0000B3, 1'b0, "R10 bad funct7", 0);
    send32(32'h0000303B, 1'b0, "R11 opw f3=011", 0);
    send32(32'h00002063, 1'b0, "R11 branch f3=010", 0);
    send32(32'h00007003, 1'b0, "R11 load f3=111", 0);
    idle(3);
    check(rej_flag, "R12 reject raised", {63'd0, rej_flag}, 64'd1);
    check(rej_off == first_bad, "R12 first offending offset",
          {32'd0, rej_off}, {32'd0, first_bad});

    // R13 reset clears, R12 latching at a later offset after a legal prefix
    do_reset();
    @(negedge clk);
    check(!rej_flag, "R13 reject cleared by reset", {63'd0, rej_flag}, 64'd0);
    send16(16'h0001,     1'b1, "R1 c.nop after reset");
    send32(32'h00510093, 1'b1, "R1 addi after reset", 1);
    send16(16'h8082,     1'b0, "R8 c.jr after reset");
    send32(32'h00000097, 1'b0, "R3 auipc after first reject", 0);
    idle(3);
    check(rej_off == first_bad, "R12 offset of first illegal",
          {32'd0, rej_off}, {32'd0, first_bad});
    check(first_bad == 32'd6, "R12 bench offset sanity",
          {32'd0, first_bad}, 64'd6);
    check(exp_q.size() == 0, "R2 every result delivered",
          exp_q.size(), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule